// File: doc/BRIEF.md
# Dual-Processor Doorbell Mailbox

This block lets two processors, side A and side B, signal each other through a shared set of registers. Each side has its own register port. Every port has a write strobe, a word address, write data and combinational read data. The block holds two 32-bit message words and four doorbell flags. Each side owns two of the flags: it can set and clear them with ordinary writes. The opposite side can read those flags, and it can clear them only by writing a one.

The flags are seen through two control views, one for each side. Each view places the side's own flags and the peer's flags at fixed positions, and it also holds two interrupt enables. A side's interrupt output is a registered level. It is high while at least one peer flag is set and enabled in that side's view. A typical handshake is: one side writes a message word, raises its own flag, and the peer takes the interrupt, reads the message, then clears the flag.

Top module: `mbx_doorbell`

## Requirements
- R1: After reset every flag, every enable and both message words are zero, and both interrupts are low.
- R2: Word index 0 (byte 0x0) is message word 0 and word index 2 (byte 0x8) is message word 1. Either port can read and write both, with full-width storage. When both ports write the same message word in the same cycle, the port B data is stored.
- R3: The view A control word is at word index 1 (byte 0x4) and reads as: bit 0 = A flag 0, bit 1 = B flag 1, bit 2 = B flag 0, bit 3 = A flag 1, bit 4 = A enable 0 (for B flag 0), bit 5 = A enable 1 (for B flag 1). Both ports can read and write it. If both ports write it in the same cycle, the port B data is used.
- R4: The view B control word is at word index 3 (byte 0xC) and reads as: bit 0 = B flag 0, bit 1 = A flag 1, bit 2 = A flag 0, bit 3 = B flag 1, bit 4 = B enable 0 (for A flag 0), bit 5 = B enable 1 (for A flag 1). Only port B can reach it.
- R5: A write to a view loads bits 0 and 3 into the flags that view's side owns, and loads bits 4 and 5 into that view's enables.
- R6: In a view write, bits 1 and 2 are write-one-to-clear for the peer-owned flags. Writing zero to them has no effect. A peer flag is never set through them.
- R7: When an owner write sets a flag in the same cycle that a peer write clears it, the flag ends up set.
- R8: irq_a_o is (B flag 0 AND A enable 0) OR (B flag 1 AND A enable 1). irq_b_o is (A flag 0 AND B enable 0) OR (A flag 1 AND B enable 1). Each interrupt is registered so that it changes on the same clock edge as the flags and enables it depends on.
- R9: A port A read of word index 3 returns zero, and a port A write to word index 3 changes nothing.
- R10: Control bits 31 to 6 read as zero, and writes to them are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_we_i | input | 1 | Port A write strobe |
| a_addr_i | input | 2 | Port A word index (byte address bits 3:2) |
| a_wdata_i | input | 32 | Port A write data |
| a_rdata_o | output | 32 | Port A read data for a_addr_i |
| b_we_i | input | 1 | Port B write strobe |
| b_addr_i | input | 2 | Port B word index |
| b_wdata_i | input | 32 | Port B write data |
| b_rdata_o | output | 32 | Port B read data for b_addr_i |
| irq_a_o | output | 1 | Side A interrupt level |
| irq_b_o | output | 1 | Side B interrupt level |

## Verification
Directed writes test each flag bit on its own. They separate an owner load from a peer clear, show that a zero in a clear bit leaves the flag alone, and raise an interrupt through a single enable. Targeted collisions cover three cases: an owner set against a peer clear, both ports writing one message word, and both ports writing view A. These show which side wins. Seeded random traffic then sends both ports to every address at once, so flag values, enables and interrupt levels appear in combinations the directed cases do not cover. That traffic also includes port A attempts on the private view.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int unsigned CTRL_W = 6;
  localparam int unsigned SIDE_A = 0;
  localparam int unsigned SIDE_B = 1;

  // bit positions inside a control view, identical for both sides
  localparam int unsigned B_OWN0  = 0;
  localparam int unsigned B_PEER1 = 1;
  localparam int unsigned B_PEER0 = 2;
  localparam int unsigned B_OWN1  = 3;
  localparam int unsigned B_EN0   = 4;
  localparam int unsigned B_EN1   = 5;

  typedef enum logic [1:0] {
    SEL_MSG_0  = 2'd0,
    SEL_CTRL_A = 2'd1,
    SEL_MSG_1  = 2'd2,
    SEL_CTRL_B = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/mbx_msg_word.sv
module mbx_msg_word #(
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          a_we_i,
  input  logic [DW-1:0] a_wdata_i,
  input  logic          b_we_i,
  input  logic [DW-1:0] b_wdata_i,
  output logic [DW-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (b_we_i) q_o <= b_wdata_i;  // port B wins a collision
    else if (a_we_i) q_o <= a_wdata_i;
  end
endmodule

// File: rtl/mbx_flag_owner.sv
module mbx_flag_owner (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       own_we_i,
  input  logic [1:0] own_val_i,
  input  logic [1:0] en_val_i,
  input  logic [1:0] peer_clr_i,
  output logic [1:0] flags_q_o,
  output logic [1:0] flags_d_o,
  output logic [1:0] en_q_o,
  output logic [1:0] en_d_o
);
  always_comb begin
    flags_d_o = flags_q_o & ~peer_clr_i;
    en_d_o    = en_q_o;
    if (own_we_i) begin
      flags_d_o = own_val_i;  // owner write beats peer clear
      en_d_o    = en_val_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q_o <= '0;
      en_q_o    <= '0;
    end else begin
      flags_q_o <= flags_d_o;
      en_q_o    <= en_d_o;
    end
  end
endmodule

// File: rtl/mbx_doorbell.sv
module mbx_doorbell
  import mbx_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          a_we_i,
  input  logic [3:2]    a_addr_i,
  input  logic [DW-1:0] a_wdata_i,
  output logic [DW-1:0] a_rdata_o,
  input  logic          b_we_i,
  input  logic [3:2]    b_addr_i,
  input  logic [DW-1:0] b_wdata_i,
  output logic [DW-1:0] b_rdata_o,
  output logic          irq_a_o,
  output logic          irq_b_o
);
  localparam int unsigned PAD_W = DW - CTRL_W;

  reg_sel_e a_sel, b_sel;
  assign a_sel = reg_sel_e'(a_addr_i);
  assign b_sel = reg_sel_e'(b_addr_i);

  logic [1:0]             view_we;
  logic [1:0][CTRL_W-1:0] view_wd;
  logic [1:0][CTRL_W-1:0] view_rd;
  logic [1:0][1:0]        flags_q, flags_d, en_q, en_d;
  logic [1:0][DW-1:0]     msg_q;
  logic [1:0]             irq_q;
  logic                   b_hit_ca;

  assign b_hit_ca         = b_we_i && (b_sel == SEL_CTRL_A);
  assign view_we[SIDE_A]  = b_hit_ca || (a_we_i && (a_sel == SEL_CTRL_A));
  assign view_wd[SIDE_A]  = b_hit_ca ? b_wdata_i[CTRL_W-1:0] : a_wdata_i[CTRL_W-1:0];
  assign view_we[SIDE_B]  = b_we_i && (b_sel == SEL_CTRL_B);
  assign view_wd[SIDE_B]  = b_wdata_i[CTRL_W-1:0];

  for (genvar m = 0; m < 2; m++) begin : g_msg
    localparam reg_sel_e SEL = (m == 0) ? SEL_MSG_0 : SEL_MSG_1;
    mbx_msg_word #(.DW(DW)) u_word (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .a_we_i   (a_we_i && (a_sel == SEL)),
      .a_wdata_i(a_wdata_i),
      .b_we_i   (b_we_i && (b_sel == SEL)),
      .b_wdata_i(b_wdata_i),
      .q_o      (msg_q[m])
    );
  end

  for (genvar s = 0; s < 2; s++) begin : g_side
    localparam int unsigned PEER = 1 - s;
    mbx_flag_owner u_owner (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .own_we_i  (view_we[s]),
      .own_val_i ({view_wd[s][B_OWN1], view_wd[s][B_OWN0]}),
      .en_val_i  ({view_wd[s][B_EN1], view_wd[s][B_EN0]}),
      .peer_clr_i({view_we[PEER] && view_wd[PEER][B_PEER1],
                   view_we[PEER] && view_wd[PEER][B_PEER0]}),
      .flags_q_o (flags_q[s]),
      .flags_d_o (flags_d[s]),
      .en_q_o    (en_q[s]),
      .en_d_o    (en_d[s])
    );

    // registered from next-state so irq moves with the flags
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) irq_q[s] <= 1'b0;
      else         irq_q[s] <= |(flags_d[PEER] & en_d[s]);
    end

    always_comb begin
      view_rd[s]          = '0;
      view_rd[s][B_OWN0]  = flags_q[s][0];
      view_rd[s][B_OWN1]  = flags_q[s][1];
      view_rd[s][B_PEER0] = flags_q[PEER][0];
      view_rd[s][B_PEER1] = flags_q[PEER][1];
      view_rd[s][B_EN0]   = en_q[s][0];
      view_rd[s][B_EN1]   = en_q[s][1];
    end
  end

  assign irq_a_o = irq_q[SIDE_A];
  assign irq_b_o = irq_q[SIDE_B];

  always_comb begin
    unique case (a_sel)
      SEL_MSG_0:  a_rdata_o = msg_q[0];
      SEL_CTRL_A: a_rdata_o = {{PAD_W{1'b0}}, view_rd[SIDE_A]};
      SEL_MSG_1:  a_rdata_o = msg_q[1];
      default:    a_rdata_o = '0;  // private to port B
    endcase
  end

  always_comb begin
    unique case (b_sel)
      SEL_MSG_0:  b_rdata_o = msg_q[0];
      SEL_CTRL_A: b_rdata_o = {{PAD_W{1'b0}}, view_rd[SIDE_A]};
      SEL_MSG_1:  b_rdata_o = msg_q[1];
      default:    b_rdata_o = {{PAD_W{1'b0}}, view_rd[SIDE_B]};
    endcase
  end
endmodule

// File: rtl/mbx_doorbell_chk.sv
module mbx_doorbell_chk #(
  parameter int unsigned DW = 32
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               a_we_i,
  input logic [3:2]         a_addr_i,
  input logic [DW-1:0]      a_wdata_i,
  input logic [DW-1:0]      a_rdata_o,
  input logic               b_we_i,
  input logic [3:2]         b_addr_i,
  input logic [DW-1:0]      b_wdata_i,
  input logic [DW-1:0]      b_rdata_o,
  input logic               irq_a_o,
  input logic               irq_b_o,
  input logic [1:0][1:0]    flags_q,
  input logic [1:0][1:0]    en_q,
  input logic [1:0][DW-1:0] msg_q
);
  logic a_wr_ca, a_wr_cb, b_wr_ca, b_wr_cb;
  assign a_wr_ca = a_we_i && (a_addr_i == 2'd1);
  assign a_wr_cb = a_we_i && (a_addr_i == 2'd3);
  assign b_wr_ca = b_we_i && (b_addr_i == 2'd1);
  assign b_wr_cb = b_we_i && (b_addr_i == 2'd3);

  assert_b_wins_msg_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_we_i && b_we_i && a_addr_i == 2'd0 && b_addr_i == 2'd0) |=> (msg_q[0] == $past(b_wdata_i)));

  assert_peer_no_set_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flags_q[1][0]) |-> $past(b_wr_cb && b_wdata_i[0]));

  assert_set_wins_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_wr_ca && !b_wr_ca && a_wdata_i[0] && b_wr_cb && b_wdata_i[2]) |=> flags_q[0][0]);

  assert_irq_a_level_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_a_o == |(flags_q[1] & en_q[0]));

  assert_irq_b_level_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_b_o == |(flags_q[0] & en_q[1]));

  assert_a_no_private_wr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_wr_cb && !b_we_i) |=> ($stable(flags_q) && $stable(en_q) && $stable(msg_q)));

  assert_a_private_rd_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_addr_i == 2'd3) |-> (a_rdata_o == '0));

  assert_ctrl_pad_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    b_addr_i[2] |-> (b_rdata_o[DW-1:6] == '0));
endmodule

bind mbx_doorbell mbx_doorbell_chk #(.DW(DW)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .a_we_i   (a_we_i),
  .a_addr_i (a_addr_i),
  .a_wdata_i(a_wdata_i),
  .a_rdata_o(a_rdata_o),
  .b_we_i   (b_we_i),
  .b_addr_i (b_addr_i),
  .b_wdata_i(b_wdata_i),
  .b_rdata_o(b_rdata_o),
  .irq_a_o  (irq_a_o),
  .irq_b_o  (irq_b_o),
  .flags_q  (flags_q),
  .en_q     (en_q),
  .msg_q    (msg_q)
);

// File: tb/tb_mbx_doorbell.sv
module tb_mbx_doorbell;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        a_we = 1'b0, b_we = 1'b0;
  logic [1:0]  a_addr = '0, b_addr = '0;
  logic [31:0] a_wdata = '0, b_wdata = '0;
  logic [31:0] a_rdata, b_rdata;
  logic        irq_a, irq_b;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  mbx_doorbell dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .a_we_i(a_we), .a_addr_i(a_addr), .a_wdata_i(a_wdata), .a_rdata_o(a_rdata),
    .b_we_i(b_we), .b_addr_i(b_addr), .b_wdata_i(b_wdata), .b_rdata_o(b_rdata),
    .irq_a_o(irq_a), .irq_b_o(irq_b)
  );

  // reference state: fl[s] = {flag1, flag0} owned by side s, en[s] = enables of view s
  logic [31:0] m_msg [2];
  logic [1:0]  m_fl  [2];
  logic [1:0]  m_en  [2];
  logic        m_irq [2];

  function automatic logic [31:0] view(input int s);
    logic [31:0] v = '0;
    v[0] = m_fl[s][0];
    v[1] = m_fl[1-s][1];
    v[2] = m_fl[1-s][0];
    v[3] = m_fl[s][1];
    v[4] = m_en[s][0];
    v[5] = m_en[s][1];
    return v;
  endfunction

  function automatic logic [31:0] exp_rd(input int side, input logic [1:0] addr);
    case (addr)
      2'd0: return m_msg[0];
      2'd1: return view(0);
      2'd2: return m_msg[1];
      default: return (side == 0) ? 32'd0 : view(1);
    endcase
  endfunction

  function automatic string auto_tag(input int side, input logic [1:0] addr);
    case (addr)
      2'd0, 2'd2: return "R2";
      2'd1: return "R3";
      default: return (side == 0) ? "R9" : "R4";
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic model_update(input bit aw, input logic [1:0] aa, input logic [31:0] ad,
                              input bit bw, input logic [1:0] ba, input logic [31:0] bd);
    bit          vwe [2];
    logic [31:0] vd  [2];
    logic [1:0]  nfl [2];
    logic [1:0]  nen [2];
    vwe[0] = (bw && ba == 2'd1) || (aw && aa == 2'd1);
    vd[0]  = (bw && ba == 2'd1) ? bd : ad;
    vwe[1] = bw && ba == 2'd3;
    vd[1]  = bd;
    for (int s = 0; s < 2; s++) begin
      int p = 1 - s;
      nfl[s] = m_fl[s];
      nen[s] = m_en[s];
      if (vwe[p] && vd[p][2]) nfl[s][0] = 1'b0;
      if (vwe[p] && vd[p][1]) nfl[s][1] = 1'b0;
      if (vwe[s]) begin
        nfl[s] = {vd[s][3], vd[s][0]};
        nen[s] = {vd[s][5], vd[s][4]};
      end
    end
    for (int s = 0; s < 2; s++) begin
      m_fl[s] = nfl[s];
      m_en[s] = nen[s];
    end
    for (int s = 0; s < 2; s++) m_irq[s] = |(m_fl[1-s] & m_en[s]);
    for (int w = 0; w < 2; w++) begin
      logic [1:0] sel = (w == 0) ? 2'd0 : 2'd2;
      if (bw && ba == sel) m_msg[w] = bd;
      else if (aw && aa == sel) m_msg[w] = ad;
    end
  endtask

  task automatic step(input bit aw, input logic [1:0] aa, input logic [31:0] ad,
                      input bit bw, input logic [1:0] ba, input logic [31:0] bd,
                      input string tag);
    string ta, tb;
    @(negedge clk);
    a_we = aw; a_addr = aa; a_wdata = ad;
    b_we = bw; b_addr = ba; b_wdata = bd;
    #1;
    ta = (tag == "") ? auto_tag(0, aa) : tag;
    tb = (tag == "") ? auto_tag(1, ba) : tag;
    chk(a_rdata == exp_rd(0, aa), {ta, " port A read"}, a_rdata, exp_rd(0, aa));
    chk(b_rdata == exp_rd(1, ba), {tb, " port B read"}, b_rdata, exp_rd(1, ba));
    chk(irq_a == m_irq[0], "R8 irq_a", {31'd0, irq_a}, {31'd0, m_irq[0]});
    chk(irq_b == m_irq[1], "R8 irq_b", {31'd0, irq_b}, {31'd0, m_irq[1]});
    @(posedge clk);
    model_update(aw, aa, ad, bw, ba, bd);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 2; i++) begin
      m_msg[i] = '0; m_fl[i] = '0; m_en[i] = '0; m_irq[i] = 1'b0;
    end
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1: every address reads zero after reset
    for (int k = 0; k < 4; k++) step(0, 2'(k), '0, 0, 2'(k), '0, "R1");
    // R5: side A raises both own flags
    step(1, 2'd1, 32'h9, 0, 2'd3, '0, "R5");
    // R6: zeros in clear bits from B have no effect
    step(0, 2'd1, '0, 1, 2'd3, 32'h0, "R6");
    step(0, 2'd1, '0, 1, 2'd3, 32'h4, "R6");
    // R8: B enables irq on A flag 1
    step(0, 2'd1, '0, 1, 2'd3, 32'h20, "R8");
    // R7: A sets flag 0 while B clears both
    step(1, 2'd1, 32'h9, 1, 2'd3, 32'h26, "R7");
    step(0, 2'd1, '0, 0, 2'd3, '0, "R7");
    // R5: owner clears own flags
    step(1, 2'd1, 32'h0, 0, 2'd3, '0, "R5");
    // R9: A write to private view ignored
    step(1, 2'd3, 32'hFFFF_FFFF, 0, 2'd3, '0, "R9");
    step(0, 2'd3, '0, 0, 2'd3, '0, "R9");
    // R2: collision on message word 0
    step(1, 2'd0, 32'hAAAA_5555, 1, 2'd0, 32'h1234_5678, "R2");
    step(0, 2'd0, '0, 0, 2'd0, '0, "R2");
    // R3: collision on view A, B data used
    step(1, 2'd1, 32'h39, 1, 2'd1, 32'h30, "R3");
    // R10: high bits written all ones read back zero
    step(1, 2'd1, 32'hFFFF_FFC9, 1, 2'd3, 32'hFFFF_FFF9, "R10");
    step(0, 2'd1, '0, 0, 2'd3, '0, "R10");

    for (int n = 0; n < 4000; n++) begin
      step(1'($urandom), 2'($urandom), $urandom, 1'($urandom), 2'($urandom), $urandom, "");
    end

    @(negedge clk);
    a_we = 1'b0; b_we = 1'b0;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule